// File: doc/BRIEF.md
# EEPROM Byte Access and Burst Loader

This block sits between a host register port and an external byte-wide EEPROM. Through five small registers the host can read one byte from the EEPROM, write one byte to it, or start a burst. A burst streams fixed-size records out of the EEPROM and turns each record into one 32-bit write on a simple memory write port that addresses a 24-bit internal space.

The EEPROM is reached through a generic byte request/acknowledge port, so any serial or parallel EEPROM controller can sit behind it. An internal byte pointer tracks the EEPROM address. Single accesses load the pointer from the address register. A burst starts from address 0 if it is the first operation after reset; otherwise it resumes from the byte after the last one touched. Each record carries a 16-bit target offset. Bit 15 of that offset is discarded, and bits 23:15 of the memory address come from the base register.

The sequencer has five states. ST_IDLE waits for a request. ST_SGL_RD and ST_SGL_WR perform one byte transfer each and return to ST_IDLE on acknowledge. ST_BST_FETCH collects record bytes, one per acknowledge. It moves to ST_BST_COMMIT after the sixth byte, or back to ST_IDLE when it sees the end marker. ST_BST_COMMIT issues the memory write and then returns to ST_BST_FETCH.

Top module: `eeprom_loader`

## Requirements
- R1: After reset, every status bit reads 0, the ADDR, DATA and BASE registers read 0, ee_req is low and mem_we is low.
- R2: The register offsets on reg_addr are: 0 = CTRL (bit 0 write request, bit 1 read request; reads return the busy state of each), 1 = ADDR, 2 = DATA (bits 7:0), 3 = BASE (bits 8:0), 4 = BURST (bit 0). Any other offset reads as 0.
- R3: Writing CTRL with bit 1 set reads the EEPROM byte at ADDR into DATA. CTRL bit 1 reads 1 until the byte has arrived, and DATA holds that byte once the bit reads 0.
- R4: Writing CTRL with bit 0 set, and bit 1 clear, writes DATA[7:0] to the EEPROM at ADDR. CTRL bit 0 reads 1 until the EEPROM acknowledges.
- R5: A CTRL write with both bit 0 and bit 1 set performs only the read.
- R6: ee_req stays high, with ee_addr and ee_we unchanged, until a one-cycle ee_ack. Each acknowledge completes exactly one byte.
- R7: A burst that is the first operation after reset starts at EEPROM address 0.
- R8: Any other burst starts at the EEPROM address one past the last byte accessed, whether that byte was single or burst.
- R9: A record is six bytes: a 16-bit offset (low byte first), then four data bytes in little-endian order. A complete record gives exactly one single-cycle mem_we pulse, with mem_wdata equal to the assembled word.
- R10: For each record, mem_addr = {BASE[8:0], offset[14:0]}. Bit 15 of the offset has no effect on the address.
- R11: A record offset of 0xFFFF ends the burst without a memory write, and BURST bit 0 then reads 0.
- R12: While any operation is busy, every host register write is dropped, including new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational from reg_addr) |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | EEPROM request is a write |
| ee_addr | output | EE_AW (16) | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM byte acknowledge, one cycle |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | 24 | Internal memory address |
| mem_wdata | output | 32 | Internal memory write word |

## Verification
The hardest situations to reach from the ports are those that depend on history: the very first burst after reset, and a burst that must resume right after a given single access. The bench handles both by ordering its directed steps. The first burst runs before any other EEPROM operation. Later, a single write to a chosen address is followed at once by a burst whose records were placed one byte beyond that address. Host writes dropped during a burst are provoked by issuing DATA, CTRL and BURST writes in the first cycles of a long burst, then reading DATA and counting memory writes afterwards. The EEPROM model acknowledges after a random delay, which exercises request holding.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SGL_RD,
        ST_SGL_WR,
        ST_BST_FETCH,
        ST_BST_COMMIT
    } seq_state_t;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_ADDR  = 3'd1;
    localparam logic [2:0] OFS_DATA  = 3'd2;
    localparam logic [2:0] OFS_BASE  = 3'd3;
    localparam logic [2:0] OFS_BURST = 3'd4;

    localparam int CTRL_WR_BIT = 0;
    localparam int CTRL_RD_BIT = 1;

endpackage

// File: rtl/eeprom_regs.sv
module eeprom_regs
    import eeprom_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             rd_busy,
    input  logic             wr_busy,
    input  logic             bst_busy,
    input  logic             data_load,
    input  logic [7:0]       data_in,
    output logic [EE_AW-1:0] addr_q,
    output logic [7:0]       data_q,
    output logic [BASE_W-1:0] base_q,
    output logic             go_rd,
    output logic             go_wr,
    output logic             go_bst
);
    logic busy;
    logic accept;

    assign busy   = rd_busy | wr_busy | bst_busy;
    assign accept = reg_we & ~busy;

    assign go_rd  = accept && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_RD_BIT];
    assign go_wr  = accept && (reg_addr == OFS_CTRL) && reg_wdata[CTRL_WR_BIT]
                    && !reg_wdata[CTRL_RD_BIT];
    assign go_bst = accept && (reg_addr == OFS_BURST) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            if (data_load) begin
                data_q <= data_in;
            end else if (accept && reg_addr == OFS_DATA) begin
                data_q <= reg_wdata[7:0];
            end
            if (accept && reg_addr == OFS_ADDR) begin
                addr_q <= reg_wdata[EE_AW-1:0];
            end
            if (accept && reg_addr == OFS_BASE) begin
                base_q <= reg_wdata[BASE_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTRL_RD_BIT] = rd_busy;
                reg_rdata[CTRL_WR_BIT] = wr_busy;
            end
            OFS_ADDR:  reg_rdata[EE_AW-1:0]  = addr_q;
            OFS_DATA:  reg_rdata[7:0]        = data_q;
            OFS_BASE:  reg_rdata[BASE_W-1:0] = base_q;
            OFS_BURST: reg_rdata[0]          = bst_busy;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eeprom_rec_asm.sv
module eeprom_rec_asm #(
    parameter int DATA_BYTES = 4,
    parameter int OFS_W      = 15,
    parameter int BASE_W     = 9,
    parameter int IDX_W      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [7:0]                byte_in,
    input  logic [BASE_W-1:0]         base_q,
    output logic                      term_hit,
    output logic [BASE_W+OFS_W-1:0]   mem_addr,
    output logic [8*DATA_BYTES-1:0]   mem_wdata
);
    localparam int HDR_BYTES = 2;

    logic [7:0] hdr_b  [HDR_BYTES];
    logic [7:0] data_b [DATA_BYTES];
    logic [15:0] rec_ofs;

    for (genvar h = 0; h < HDR_BYTES; h++) begin : g_hdr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hdr_b[h] <= '0;
            end else if (cap_en && idx == IDX_W'(h)) begin
                hdr_b[h] <= byte_in;
            end
        end
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_b[g] <= '0;
            end else if (cap_en && idx == IDX_W'(HDR_BYTES + g)) begin
                data_b[g] <= byte_in;
            end
        end
        assign mem_wdata[8*g +: 8] = data_b[g];
    end

    assign rec_ofs  = {hdr_b[1], hdr_b[0]};
    assign mem_addr = {base_q, rec_ofs[OFS_W-1:0]};
    assign term_hit = cap_en && (idx == IDX_W'(1)) && ({byte_in, hdr_b[0]} == 16'hFFFF);

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeprom_pkg::*;
#(
    parameter int EE_AW     = 16,
    parameter int REC_BYTES = 6,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_rd,
    input  logic             go_wr,
    input  logic             go_bst,
    input  logic [EE_AW-1:0] addr_q,
    input  logic             ee_ack,
    input  logic             term_hit,
    output logic             ee_req,
    output logic             ee_we,
    output logic [EE_AW-1:0] ee_addr,
    output logic             rd_busy,
    output logic             wr_busy,
    output logic             bst_busy,
    output logic             data_load,
    output logic             cap_en,
    output logic [IDX_W-1:0] idx,
    output logic             mem_we
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

    seq_state_t      st_q, st_d;
    logic [EE_AW-1:0] ptr_q;
    logic            fresh_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_rd)       st_d = ST_SGL_RD;
                else if (go_wr)  st_d = ST_SGL_WR;
                else if (go_bst) st_d = ST_BST_FETCH;
            end
            ST_SGL_RD:  if (ee_ack) st_d = ST_IDLE;
            ST_SGL_WR:  if (ee_ack) st_d = ST_IDLE;
            ST_BST_FETCH: begin
                if (ee_ack) begin
                    if (term_hit)               st_d = ST_IDLE;
                    else if (idx_q == LAST_IDX) st_d = ST_BST_COMMIT;
                end
            end
            ST_BST_COMMIT: st_d = ST_BST_FETCH;
            default:       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            fresh_q <= 1'b1;
            idx_q   <= '0;
        end else begin
            if (st_q == ST_IDLE) begin
                if (go_rd || go_wr) begin
                    ptr_q   <= addr_q;
                    fresh_q <= 1'b0;
                end else if (go_bst) begin
                    if (fresh_q) ptr_q <= '0;
                    fresh_q <= 1'b0;
                    idx_q   <= '0;
                end
            end else if (ee_ack && ee_req) begin
                ptr_q <= ptr_q + 1'b1;
                if (st_q == ST_BST_FETCH) begin
                    if (term_hit || idx_q == LAST_IDX) idx_q <= '0;
                    else                               idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        ee_req    = 1'b0;
        ee_we     = 1'b0;
        rd_busy   = 1'b0;
        wr_busy   = 1'b0;
        bst_busy  = 1'b0;
        data_load = 1'b0;
        cap_en    = 1'b0;
        mem_we    = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_SGL_RD: begin
                ee_req    = 1'b1;
                rd_busy   = 1'b1;
                data_load = ee_ack;
            end
            ST_SGL_WR: begin
                ee_req  = 1'b1;
                ee_we   = 1'b1;
                wr_busy = 1'b1;
            end
            ST_BST_FETCH: begin
                ee_req   = 1'b1;
                bst_busy = 1'b1;
                cap_en   = ee_ack;
            end
            ST_BST_COMMIT: begin
                bst_busy = 1'b1;
                mem_we   = 1'b1;
            end
            default: ;
        endcase
    end

    assign ee_addr = ptr_q;
    assign idx     = idx_q;

endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
    import eeprom_pkg::*;
#(
    parameter int EE_AW      = 16,
    parameter int BASE_W     = 9,
    parameter int OFS_W      = 15,
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [2:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    ee_req,
    output logic                    ee_we,
    output logic [EE_AW-1:0]        ee_addr,
    output logic [7:0]              ee_wdata,
    input  logic                    ee_ack,
    input  logic [7:0]              ee_rdata,
    output logic                    mem_we,
    output logic [BASE_W+OFS_W-1:0] mem_addr,
    output logic [8*DATA_BYTES-1:0] mem_wdata
);
    localparam int REC_BYTES = 2 + DATA_BYTES;
    localparam int IDX_W     = $clog2(REC_BYTES);

    logic             rd_busy, wr_busy, bst_busy;
    logic             data_load, cap_en, term_hit;
    logic             go_rd, go_wr, go_bst;
    logic [IDX_W-1:0] idx;
    logic [EE_AW-1:0] addr_q;
    logic [7:0]       data_q;
    logic [BASE_W-1:0] base_q;

    eeprom_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_busy(rd_busy), .wr_busy(wr_busy), .bst_busy(bst_busy),
        .data_load(data_load), .data_in(ee_rdata),
        .addr_q(addr_q), .data_q(data_q), .base_q(base_q),
        .go_rd(go_rd), .go_wr(go_wr), .go_bst(go_bst)
    );

    eeprom_seq #(.EE_AW(EE_AW), .REC_BYTES(REC_BYTES), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go_rd(go_rd), .go_wr(go_wr), .go_bst(go_bst), .addr_q(addr_q),
        .ee_ack(ee_ack), .term_hit(term_hit),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
        .rd_busy(rd_busy), .wr_busy(wr_busy), .bst_busy(bst_busy),
        .data_load(data_load), .cap_en(cap_en), .idx(idx), .mem_we(mem_we)
    );

    eeprom_rec_asm #(.DATA_BYTES(DATA_BYTES), .OFS_W(OFS_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .idx(idx), .byte_in(ee_rdata), .base_q(base_q),
        .term_hit(term_hit), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    assign ee_wdata = data_q;

endmodule

// File: rtl/eeprom_loader_chk.sv
module eeprom_loader_chk #(
    parameter int EE_AW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ee_req,
    input logic             ee_we,
    input logic             ee_ack,
    input logic [EE_AW-1:0] ee_addr,
    input logic             mem_we,
    input logic             rd_busy,
    input logic             wr_busy,
    input logic             bst_busy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we))); // R6

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && ee_ack) |=> !rd_busy); // R3

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && ee_ack) |=> !wr_busy); // R4

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R9

    AST_COMMIT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bst_busy && !ee_req)); // R9

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_busy, wr_busy, bst_busy})); // R12

    AST_BURST_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bst_busy |-> !ee_we); // R6

endmodule

bind eeprom_loader eeprom_loader_chk #(.EE_AW(EE_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_we(ee_we), .ee_ack(ee_ack),
    .ee_addr(ee_addr), .mem_we(mem_we), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .bst_busy(bst_busy)
);

// File: tb/eeprom_loader_test.sv
module eeprom_loader_test;
    localparam int EE_AW = 10;
    localparam int EE_SZ = 1 << EE_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [EE_AW-1:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = 8'd0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;

    always #5 clk = ~clk;

    eeprom_loader #(.EE_AW(EE_AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // EEPROM model with random acknowledge latency
    logic [7:0] ee_mem [EE_SZ];
    int unsigned lat = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ee_ack <= 1'b0;
        end else if (ee_ack) begin
            ee_ack <= 1'b0;
        end else if (ee_req) begin
            if (lat == 0) begin
                ee_ack   <= 1'b1;
                ee_rdata <= ee_mem[ee_addr];
                if (ee_we) ee_mem[ee_addr] <= ee_wdata;
                lat <= $urandom_range(0, 2);
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // Memory-port monitor
    logic [23:0] cap_addr [64];
    logic [31:0] cap_data [64];
    int cap_n = 0;
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (cap_n < 64) begin
                cap_addr[cap_n] <= mem_addr;
                cap_data[cap_n] <= mem_wdata;
            end
            cap_n <= cap_n + 1;
        end
    end

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired act=%0d exp=<done>", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [23:0] exp_maddr(input logic [8:0] b, input logic [15:0] o);
        return {b, o[14:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c, b;
        for (int i = 0; i < 2000; i++) begin
            host_rd(3'd0, c);
            host_rd(3'd4, b);
            if (c == 0 && b == 0) return;
        end
        fails++;
        $display("FAIL R3 operation never finished act=busy exp=idle");
    endtask

    task automatic put_rec(inout int p, input logic [15:0] o, input logic [31:0] d);
        ee_mem[p[EE_AW-1:0]]       = o[7:0];
        ee_mem[(p+1) % EE_SZ]      = o[15:8];
        for (int k = 0; k < 4; k++) ee_mem[(p+2+k) % EE_SZ] = d[8*k +: 8];
        p = p + 6;
    endtask

    task automatic put_end(inout int p);
        ee_mem[p % EE_SZ]     = 8'hFF;
        ee_mem[(p+1) % EE_SZ] = 8'hFF;
        p = p + 2;
    endtask

    initial begin
        logic [31:0] v;
        int p, c0;
        logic [15:0] ofs [4];
        logic [31:0] dat [4];
        void'($urandom(32'd4711));
        for (int i = 0; i < EE_SZ; i++) ee_mem[i] = 8'(i ^ 8'h5C);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state
        host_rd(3'd0, v); check("R1 CTRL after reset", v, 32'd0);
        host_rd(3'd4, v); check("R1 BURST after reset", v, 32'd0);
        host_rd(3'd2, v); check("R1 DATA after reset", v, 32'd0);
        host_rd(3'd1, v); check("R1 ADDR after reset", v, 32'd0);
        check("R1 no request after reset", {31'd0, ee_req}, 32'd0);
        check("R1 no memory write after reset", {31'd0, mem_we}, 32'd0);
        host_rd(3'd6, v); check("R2 unmapped offset reads 0", v, 32'd0);
        host_wr(3'd3, 32'hFFFF_F1A5);
        host_rd(3'd3, v); check("R2 BASE keeps 9 bits", v, 32'h1A5);

        // R7/R9/R10/R11: first burst after reset starts at 0
        ofs[0] = 16'h0010; dat[0] = 32'hDEADBEEF;
        ofs[1] = 16'h8123; dat[1] = 32'h01234567;
        ofs[2] = 16'h7FFF; dat[2] = 32'hA5A5_0F0F;
        p = 0;
        for (int r = 0; r < 3; r++) put_rec(p, ofs[r], dat[r]);
        put_end(p);
        c0 = cap_n;
        host_wr(3'd4, 32'd1);
        host_rd(3'd4, v); check("R2 BURST busy bit", v, 32'd1);
        wait_idle();
        host_rd(3'd4, v); check("R11 BURST clears at end marker", v, 32'd0);
        check("R11 record count before end marker", cap_n - c0, 32'd3);
        for (int r = 0; r < 3; r++) begin
            check("R7 R10 memory address", {8'd0, cap_addr[c0+r]}, {8'd0, exp_maddr(9'h1A5, ofs[r])});
            check("R9 memory data", cap_data[c0+r], dat[r]);
        end

        // R4 + R8: single write then burst resumes at next byte
        host_wr(3'd1, 32'h200);
        host_wr(3'd2, 32'h3C);
        host_wr(3'd0, 32'h1);
        host_rd(3'd0, v); check("R4 write busy bit", v, 32'h1);
        wait_idle();
        check("R4 byte written", {24'd0, ee_mem[10'h200]}, 32'h3C);
        host_wr(3'd3, 32'h0F0);
        p = 16'h201;
        put_rec(p, 16'h0456, 32'hCAFEF00D);
        put_end(p);
        c0 = cap_n;
        host_wr(3'd4, 32'd1);
        wait_idle();
        check("R8 resumed burst record count", cap_n - c0, 32'd1);
        check("R8 resumed burst address", {8'd0, cap_addr[c0]}, {8'd0, exp_maddr(9'h0F0, 16'h0456)});
        check("R8 resumed burst data", cap_data[c0], 32'hCAFEF00D);

        // R8 again: burst continues after the previous burst's end marker
        p = 16'h201 + 8;
        put_rec(p, 16'h0001, 32'h11223344);
        put_end(p);
        c0 = cap_n;
        host_wr(3'd4, 32'd1);
        wait_idle();
        check("R8 burst after burst count", cap_n - c0, 32'd1);
        check("R8 burst after burst data", cap_data[c0], 32'h11223344);

        // R12: writes dropped while a long burst runs
        host_wr(3'd2, 32'h66);
        host_wr(3'd1, 32'h300);
        host_wr(3'd0, 32'h2);           // read 0x300 to place pointer
        wait_idle();
        check("R3 single read byte", reg_rdata & 32'h0, 32'h0);
        host_rd(3'd2, v); check("R3 single read byte", v, {24'd0, ee_mem[10'h300]});
        p = 16'h301;
        for (int r = 0; r < 4; r++) put_rec(p, 16'(16'h20 + r), 32'(r * 32'h01010101));
        put_end(p);
        c0 = cap_n;
        host_wr(3'd4, 32'd1);
        host_wr(3'd2, 32'hA5);
        host_wr(3'd0, 32'h2);
        host_wr(3'd4, 32'd1);
        host_wr(3'd1, 32'h3FF);
        wait_idle();
        host_rd(3'd2, v); check("R12 DATA write dropped while busy", v, {24'd0, ee_mem[10'h300]});
        host_rd(3'd1, v); check("R12 ADDR write dropped while busy", v, 32'h300);
        check("R12 extra burst request dropped", cap_n - c0, 32'd4);

        // R5: both request bits -> read only
        ee_mem[10'h150] = 8'h77;
        host_wr(3'd1, 32'h150);
        host_wr(3'd2, 32'h33);
        host_wr(3'd0, 32'h3);
        host_rd(3'd0, v); check("R5 only read busy", v, 32'h2);
        wait_idle();
        host_rd(3'd2, v); check("R5 read performed", v, 32'h77);
        check("R5 no write performed", {24'd0, ee_mem[10'h150]}, 32'h77);

        // R3/R4/R6: random single accesses
        for (int n = 0; n < 24; n++) begin
            logic [9:0] a;
            logic [7:0] d;
            a = 10'($urandom_range(0, EE_SZ - 1));
            d = 8'($urandom_range(0, 255));
            host_wr(3'd1, {22'd0, a});
            if ($urandom_range(0, 1) == 1) begin
                host_wr(3'd2, {24'd0, d});
                host_wr(3'd0, 32'h1);
                wait_idle();
                check("R4 R6 random write", {24'd0, ee_mem[a]}, {24'd0, d});
            end else begin
                host_wr(3'd0, 32'h2);
                wait_idle();
                host_rd(3'd2, v);
                check("R3 R6 random read", v, {24'd0, ee_mem[a]});
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule